// File: doc/BRIEF.md
# Staged Power-Good Output Sequencer

This block turns on three downstream loads in a fixed order once the main power switch of a plug-in card is confirmed fully on. It watches a qualified gate-on flag, a drain-low flag that says the switch is saturated, a breaker-fault flag and a master enable. When all four agree, the first power-good output pulls low. The second output follows after one programmable stage delay. The third follows after a further stage delay.

Each output is modelled as an open-drain pin. A per-output enable says whether the pin pulls low. A companion level shows what the pin reads with an external pull-up. Two enable inputs gate the later stages. Enable A gates outputs 2 and 3. Enable B gates output 3 alone. When an enable returns and the earlier stage has already waited its delay, the gated output reasserts at once.

The stage delay is one of four cycle counts, chosen by a 2-bit select. The default counts stand for 5, 20, 80 and 160 ms at a 1 MHz clock. The select is meant to be a static strap while a sequence runs.

Top module: `pg_stager`

## Requirements
- R1: While `rst_n` is low, `pg_oe_o` is 3'b000 and `pg_n_o` is 3'b111, so every output is released.
- R2: Output 1 (bit 0) pulls low on the first clock edge at which `gate_on_i`, `drain_low_i` and `master_en_i` are high and `brk_fault_i` is low. It stays released while any of those is missing.
- R3: With `en_a_i` high, output 2 (bit 1) pulls low exactly D cycles after output 1 pulled low. D is the stage delay in clock cycles.
- R4: With both enables high, output 3 (bit 2) pulls low exactly D cycles after output 2, which is 2·D cycles after output 1.
- R5: `dly_sel_i` values 0, 1, 2 and 3 select D = `DLY_C0`, `DLY_C1`, `DLY_C2` and `DLY_C3` respectively.
- R6: Taking `en_a_i` low releases outputs 2 and 3 on the next edge. Taking it high again, once output 1 has been active for D cycles, pulls output 2 low on the next edge, and output 3 follows D cycles after that.
- R7: Taking `en_b_i` low releases output 3 on the next edge. Taking it high while output 2 has been active for D cycles pulls output 3 low on the next edge.
- R8: A breaker fault, loss of gate-on, loss of drain-low or master enable low releases all three outputs on the next edge. It also restarts the timing, so the next qualification again waits D and 2·D.
- R9: For every bit k, `pg_n_o[k]` is 0 exactly when `pg_oe_o[k]` is 1.
- R10: Output 2 is never active without output 1, and output 3 is never active without output 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_on_i | input | 1 | Qualified switch gate-on flag |
| drain_low_i | input | 1 | Switch drain is low (switch fully on) |
| brk_fault_i | input | 1 | Circuit breaker has tripped |
| master_en_i | input | 1 | Master enable |
| en_a_i | input | 1 | Enable for outputs 2 and 3 |
| en_b_i | input | 1 | Enable for output 3 |
| dly_sel_i | input | 2 | Stage delay select |
| pg_oe_o | output | 3 | Pull-low enable per output (bit 0 = output 1) |
| pg_n_o | output | 3 | Pin level with external pull-up, active low |

## Verification
Every output change is due on the first clock edge after its cause. Output 1 is due one edge after the qualifying inputs are all present. Each gating or fault change lands one edge after its input moves. Outputs 2 and 3 land exactly D and 2·D edges after output 1. The bench drives inputs and samples outputs on the falling edge. Its directed checks sit at D−1 and D cycles, and at 2·D−1 and 2·D cycles, to catch an off-by-one in either direction. A behavioural model counts consecutive qualified cycles with integers and is compared against the outputs on every falling edge.

// File: rtl/pg_stager_pkg.sv
package pg_stager_pkg;
  localparam int NUM_PG = 3;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/pg_stage_timer.sv
// Counts cycles while run is high, saturating at the limit; done once limit reached.
module pg_stage_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q < limit) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q >= limit);
endmodule

// File: rtl/pg_od_model.sv
// Open-drain pin model: pull-low enable and the level seen with an external pull-up.
module pg_od_model #(
  parameter int N = 3
) (
  input  logic [N-1:0] act,
  output logic [N-1:0] oe,
  output logic [N-1:0] lvl_n
);
  for (genvar k = 0; k < N; k++) begin : g_pin
    assign oe[k]    = act[k];
    assign lvl_n[k] = act[k] ? 1'b0 : 1'b1;
  end
endmodule

// File: rtl/pg_stager.sv
module pg_stager
  import pg_stager_pkg::*;
#(
  parameter int unsigned DLY_C0 = 5000,
  parameter int unsigned DLY_C1 = 20000,
  parameter int unsigned DLY_C2 = 80000,
  parameter int unsigned DLY_C3 = 160000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gate_on_i,
  input  logic       drain_low_i,
  input  logic       brk_fault_i,
  input  logic       master_en_i,
  input  logic       en_a_i,
  input  logic       en_b_i,
  input  logic [1:0] dly_sel_i,
  output logic [2:0] pg_oe_o,
  output logic [2:0] pg_n_o
);
  localparam int unsigned DMAX = max4(DLY_C0, DLY_C1, DLY_C2, DLY_C3);
  localparam int W = $clog2(DMAX + 1);
  localparam logic [W-1:0] L0 = W'(DLY_C0);
  localparam logic [W-1:0] L1 = W'(DLY_C1);
  localparam logic [W-1:0] L2 = W'(DLY_C2);
  localparam logic [W-1:0] L3 = W'(DLY_C3);
  localparam int NSTG = NUM_PG - 1;

  logic [W-1:0]      stage_lim;
  logic              qual;
  logic [NUM_PG-1:0] act_q, act_d;
  logic [NSTG-1:0]   tmr_run, tmr_done;

  always_comb begin
    case (dly_sel_i)
      2'd0:    stage_lim = L0;
      2'd1:    stage_lim = L1;
      2'd2:    stage_lim = L2;
      default: stage_lim = L3;
    endcase
  end

  assign qual = gate_on_i & drain_low_i & master_en_i & ~brk_fault_i;

  // Stage timers: timer 0 measures output 1 age, timer 1 measures output 2 age.
  assign tmr_run[0] = qual;
  assign tmr_run[1] = qual & en_a_i & tmr_done[0];

  for (genvar s = 0; s < NSTG; s++) begin : g_tmr
    pg_stage_timer #(.W(W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (tmr_run[s]),
      .limit (stage_lim),
      .done  (tmr_done[s])
    );
  end

  always_comb begin
    act_d[0] = qual;
    act_d[1] = tmr_run[1];
    act_d[2] = qual & en_a_i & en_b_i & tmr_done[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  pg_od_model #(.N(NUM_PG)) u_od (
    .act   (act_q),
    .oe    (pg_oe_o),
    .lvl_n (pg_n_o)
  );
endmodule

// File: rtl/pg_stager_chk.sv
module pg_stager_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gate_on_i,
  input logic       drain_low_i,
  input logic       brk_fault_i,
  input logic       master_en_i,
  input logic       en_a_i,
  input logic       en_b_i,
  input logic [2:0] pg_oe_o,
  input logic [2:0] pg_n_o
);
  a_r10_order2: assert property (@(posedge clk) disable iff (!rst_n)
    pg_oe_o[1] |-> pg_oe_o[0]);
  a_r10_order3: assert property (@(posedge clk) disable iff (!rst_n)
    pg_oe_o[2] |-> pg_oe_o[1]);
  a_r8_fault_release: assert property (@(posedge clk) disable iff (!rst_n)
    brk_fault_i |=> (pg_oe_o == 3'b000));
  a_r8_master_release: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en_i |=> (pg_oe_o == 3'b000));
  a_r6_ena_release: assert property (@(posedge clk) disable iff (!rst_n)
    !en_a_i |=> (pg_oe_o[2:1] == 2'b00));
  a_r7_enb_release: assert property (@(posedge clk) disable iff (!rst_n)
    !en_b_i |=> !pg_oe_o[2]);
  a_r2_rise_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_oe_o[0]) |-> $past(gate_on_i && drain_low_i && master_en_i && !brk_fault_i));
  a_r9_level: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_n_o & pg_oe_o) == 3'b000);
endmodule

bind pg_stager pg_stager_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gate_on_i   (gate_on_i),
  .drain_low_i (drain_low_i),
  .brk_fault_i (brk_fault_i),
  .master_en_i (master_en_i),
  .en_a_i      (en_a_i),
  .en_b_i      (en_b_i),
  .pg_oe_o     (pg_oe_o),
  .pg_n_o      (pg_n_o)
);

// File: tb/pg_stager_tb.sv
module pg_stager_tb;
  localparam int CLK_PERIOD = 10;
  localparam int D0 = 4, D1 = 7, D2 = 11, D3 = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gate_on = 1'b0, drain_low = 1'b0, fault = 1'b0, men = 1'b0;
  logic       en_a = 1'b0, en_b = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [2:0] oe, lvl;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  pg_stager #(.DLY_C0(D0), .DLY_C1(D1), .DLY_C2(D2), .DLY_C3(D3)) u_dut (
    .clk(clk), .rst_n(rst_n), .gate_on_i(gate_on), .drain_low_i(drain_low),
    .brk_fault_i(fault), .master_en_i(men), .en_a_i(en_a), .en_b_i(en_b),
    .dly_sel_i(sel), .pg_oe_o(oe), .pg_n_o(lvl));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int dsel(logic [1:0] s);
    case (s)
      2'd0: return D0;
      2'd1: return D1;
      2'd2: return D2;
      default: return D3;
    endcase
  endfunction

  // Behavioural model: q_run = consecutive qualified edges, a_run = consecutive
  // edges with output 2 allowed; outputs follow from those counts.
  int q_run, a_run;
  logic [2:0] m_oe;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_run = 0; a_run = 0; m_oe = 3'b000;
    end else begin
      bit q, a2, a3;
      int d;
      d  = dsel(sel);
      q  = gate_on && drain_low && men && !fault;
      a2 = q && en_a && (q_run >= d);
      a3 = q && en_a && en_b && (a_run >= d);
      m_oe = {a3, a2, q};
      a_run = a2 ? a_run + 1 : 0;
      q_run = q ? q_run + 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_chk++;
      if (oe !== m_oe || lvl !== ~m_oe) begin
        n_fail++;
        $display("FAIL model R9 oe=%b lvl=%b expected oe=%b lvl=%b", oe, lvl, m_oe, ~m_oe);
      end
    end
  end

  task automatic chk(string tag, logic [2:0] exp);
    n_chk++;
    if (oe !== exp || lvl !== ~exp) begin
      n_fail++;
      $display("FAIL %s: oe=%b lvl=%b expected oe=%b lvl=%b", tag, oe, lvl, exp, ~exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic qualify(bit v);
    gate_on = v; drain_low = v; men = v; fault = 1'b0;
  endtask

  // Full ramp with both enables high; leaves all three outputs active.
  task automatic ramp(logic [1:0] s);
    int d;
    d = dsel(s);
    sel = s; en_a = 1'b1; en_b = 1'b1;
    qualify(1'b1);
    step(1);   chk("R2 output 1 on first edge", 3'b001);
    step(d-1); chk("R3 output 2 not before D", 3'b001);
    step(1);   chk("R3 output 2 at D", 3'b011);
    step(d-1); chk("R4 output 3 not before 2D", 3'b011);
    step(1);   chk("R4 R5 output 3 at 2D", 3'b111);
  endtask

  initial begin
    step(3);
    chk("R1 reset released", 3'b000);
    @(negedge clk); rst_n = 1'b1;
    step(2); chk("R1 idle after reset", 3'b000);

    // R2: missing drain-low keeps everything off
    gate_on = 1'b1; men = 1'b1; en_a = 1'b1; en_b = 1'b1;
    step(30); chk("R2 no drain-low", 3'b000);
    drain_low = 1'b1; men = 1'b0;
    step(10); chk("R2 master enable low", 3'b000);

    ramp(2'd0);
    qualify(1'b0); step(1); chk("R8 gate loss releases all", 3'b000);
    step(2);
    ramp(2'd3);
    // R6: enable A toggling
    en_a = 1'b0; step(1); chk("R6 en_a low releases 2 and 3", 3'b001);
    step(20); chk("R6 stays released", 3'b001);
    en_a = 1'b1; step(1); chk("R6 output 2 immediate", 3'b011);
    step(D3-1); chk("R6 output 3 waits D", 3'b011);
    step(1); chk("R6 output 3 after D", 3'b111);
    // R7: enable B toggling
    en_b = 1'b0; step(1); chk("R7 en_b low releases 3", 3'b011);
    step(5);
    en_b = 1'b1; step(1); chk("R7 output 3 immediate", 3'b111);
    // R8: fault then restart timing
    fault = 1'b1; step(1); chk("R8 fault releases all", 3'b000);
    fault = 1'b0; step(1); chk("R8 output 1 back", 3'b001);
    step(D3-1); chk("R8 delay restarted", 3'b001);
    step(1); chk("R8 output 2 after full D", 3'b011);
    qualify(1'b0); step(3);

    // R7 with en_b low from the start, sel=1
    sel = 2'd1; en_a = 1'b1; en_b = 1'b0; qualify(1'b1);
    step(2*D1 + 5); chk("R7 output 3 held by en_b", 3'b011);
    en_b = 1'b1; step(1); chk("R7 output 3 on enable", 3'b111);
    qualify(1'b0); step(3);

    // R6 with en_a low from the start, sel=2
    sel = 2'd2; en_a = 1'b0; en_b = 1'b1; qualify(1'b1);
    step(D2 + 5); chk("R6 output 2 held by en_a", 3'b001);
    en_a = 1'b1; step(1); chk("R6 output 2 on enable", 3'b011);
    step(D2); chk("R5 sel 2 output 3 after D", 3'b111);
    men = 1'b0; step(1); chk("R8 master enable low", 3'b000);
    qualify(1'b0); step(2);
    ramp(2'd1);
    step(3);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule